// File: doc/BRIEF.md
# Reset Boot Selector with Boot-ROM Shadow Window

This block settles two things for the code-fetch path of a small controller. The first is the address at which instruction fetch begins once reset is released. The second is whether a fetch that lands in the top kilobyte of the 64 KB code space is served by the boot ROM or by the user flash.

While reset is held, the block keeps capturing three things: a nonvolatile status byte, a nonvolatile vector byte and three strap pins. The values seen on the last clock edge with reset high are the ones kept, and they stay frozen until the next reset.

A zero status byte, with no forcing strap pattern, gives a normal start at 0000h. Either a nonzero status byte or the forcing strap pattern redirects the start to the vector byte followed by 00h. Such an entry also sets the boot-enable bit of an 8-bit control register. Software may rewrite that register at any time after reset, and must set the bit itself before it calls into boot ROM routines.

The shadow window covers FC00h–FFFFh. A fetch inside the window goes to the ROM only while the boot-enable bit is 1. A fetch below the window always goes to flash.

Top module: `reset_boot_selector`

## Requirements
- R1: With a status byte of 00h and no forcing strap pattern at the last reset clock, start_pc is 0000h and ctl_q is 00h after reset.
- R2: With a nonzero status byte at the last reset clock, start_pc is {nv_vector, 00h}; the default vector FCh gives FC00h.
- R3: The forcing strap pattern is strap_store_en_n=0, strap_ext_access=1 and strap_latch_en=1. With a zero status byte, this pattern gives the same start_pc and ctl_q as a nonzero status byte. Any other strap combination has no effect.
- R4: A boot entry through the status byte or the straps leaves ctl_q bit 5 (boot enable) at 1 after reset. A normal entry leaves it at 0. All other ctl_q bits reset to 0.
- R5: With reset low, ctl_wr high at a clock edge loads ctl_wdata into ctl_q, and the new value is visible from that edge on. Without ctl_wr, ctl_q holds its value.
- R6: A fetch_addr in FC00h–FFFFh gives rom_sel=1 when ctl_q bit 5 is 1, and rom_sel=0 when it is 0.
- R7: A fetch_addr below FC00h gives rom_sel=0 whatever the value of ctl_q bit 5.
- R8: Changes to the status byte, the vector byte or the straps after reset is released do not change start_pc or ctl_q until the next reset.
- R9: When both bytes are in the erased state FFh, start_pc is FF00h and ctl_q bit 5 is 1.
- R10: rom_sel follows fetch_addr and ctl_q in the same cycle, with no register in between.
- R11: ctl_wr is ignored while reset is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the last edge with rst high samples the boot inputs |
| strap_store_en_n | input | 1 | Program-store-enable strap, low active |
| strap_ext_access | input | 1 | External-access strap |
| strap_latch_en | input | 1 | Address-latch-enable strap (floating reads high) |
| nv_status | input | 8 | Nonvolatile status byte |
| nv_vector | input | 8 | Nonvolatile boot vector byte (high byte of boot start) |
| ctl_wr | input | 1 | Software write strobe for the control register |
| ctl_wdata | input | 8 | Software write data for the control register |
| fetch_addr | input | 16 | Current code fetch address |
| start_pc | output | 16 | Start address for instruction fetch after reset |
| ctl_q | output | 8 | Control/status register; bit 5 is boot enable |
| rom_sel | output | 1 | 1: fetch served by boot ROM, 0: by user flash |

## Verification
start_pc and ctl_q take their post-reset values on the last edge with rst high. A software write shows in ctl_q one edge after the cycle in which ctl_wr is high. rom_sel responds within the same cycle as fetch_addr.

The bench drives inputs just after each rising edge and advances a behavioural model on that same rising edge. It then compares all three outputs at the falling edge, so every result is read half a cycle after the edge that produced it.

Scenarios cover the following:
- each entry cause, including a strap pattern that is only partly met and the erased bytes;
- input changes after reset;
- software rewrites of the control register;
- writes attempted during reset;
- fetches on both sides of FC00h.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef struct packed {
        logic store_en_n;
        logic ext_access;
        logic latch_en;
    } strap_t;

    function automatic logic strap_forces_boot(strap_t s);
        return (!s.store_en_n) && s.ext_access && s.latch_en;
    endfunction

endpackage

// File: rtl/rbs_sampler.sv
module rbs_sampler
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strap_t            straps,
    input  logic [BYTE_W-1:0] status_b,
    input  logic [BYTE_W-1:0] vector_b,
    output logic              entry_now,
    output logic              boot_entry,
    output logic [ADDR_W-1:0] start_pc
);
    localparam int LOW_W = ADDR_W - BYTE_W;

    logic past_rst;

    always_comb begin
        entry_now = (status_b != '0) || strap_forces_boot(straps);
    end

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (rst) begin
            boot_entry <= entry_now;
            start_pc   <= entry_now ? {vector_b, {LOW_W{1'b0}}} : '0;
        end
    end

    // R8: once out of reset, the start address never moves
    a_r8_pc_held: assert property (@(posedge clk) disable iff (rst)
        !past_rst |-> $stable(start_pc));

    // R2: a boot entry always starts on a page boundary
    a_r2_page_start: assert property (@(posedge clk) disable iff (rst)
        boot_entry |-> (start_pc[LOW_W-1:0] == '0));

    // R1: a normal entry starts at zero
    a_r1_normal_zero: assert property (@(posedge clk) disable iff (rst)
        !boot_entry |-> (start_pc == '0));

endmodule

// File: rtl/rbs_ctl_reg.sv
module rbs_ctl_reg #(
    parameter int BYTE_W = 8,
    parameter int EN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              entry_now,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ctl_q
);
    logic [BYTE_W-1:0] rst_val;

    always_comb begin
        rst_val         = '0;
        rst_val[EN_BIT] = entry_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= rst_val;
        end else if (wr) begin
            ctl_q <= wdata;
        end
    end

    // R5: no write, no change
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctl_q));

    // R5: a write lands on the next edge
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl_q == $past(wdata)));

endmodule

// File: rtl/rbs_shadow_mux.sv
module rbs_shadow_mux #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              boot_en,
    output logic              rom_sel
);
    localparam int TOP_W = ADDR_W - WIN_W;
    localparam logic [ADDR_W-1:0] WIN_BASE = {{TOP_W{1'b1}}, {WIN_W{1'b0}}};

    logic in_window;

    always_comb begin
        in_window = &fetch_addr[ADDR_W-1:WIN_W];
        rom_sel   = in_window && boot_en;
    end

    // R7: nothing below the window ever reaches the ROM
    a_r7_below_window: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr < WIN_BASE) |-> !rom_sel);

endmodule

// File: rtl/reset_boot_selector.sv
module reset_boot_selector
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int WIN_W  = 10,
    parameter int EN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_store_en_n,
    input  logic              strap_ext_access,
    input  logic              strap_latch_en,
    input  logic [BYTE_W-1:0] nv_status,
    input  logic [BYTE_W-1:0] nv_vector,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] start_pc,
    output logic [BYTE_W-1:0] ctl_q,
    output logic              rom_sel
);
    strap_t straps;
    logic   entry_now;
    logic   boot_entry;
    logic   past_rst;

    always_comb begin
        straps.store_en_n = strap_store_en_n;
        straps.ext_access = strap_ext_access;
        straps.latch_en   = strap_latch_en;
    end

    rbs_sampler #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .straps     (straps),
        .status_b   (nv_status),
        .vector_b   (nv_vector),
        .entry_now  (entry_now),
        .boot_entry (boot_entry),
        .start_pc   (start_pc)
    );

    rbs_ctl_reg #(.BYTE_W(BYTE_W), .EN_BIT(EN_BIT)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .entry_now (entry_now),
        .wr        (ctl_wr),
        .wdata     (ctl_wdata),
        .ctl_q     (ctl_q)
    );

    rbs_shadow_mux #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_mux (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .boot_en    (ctl_q[EN_BIT]),
        .rom_sel    (rom_sel)
    );

    always_ff @(posedge clk) begin
        past_rst <= rst;
    end

    // R4: right after reset, boot enable matches the sampled entry cause
    a_r4_enable_follows_entry: assert property (@(posedge clk) disable iff (rst)
        past_rst |-> (ctl_q[EN_BIT] == boot_entry));

    // R6: the ROM is only selected while boot enable is set
    a_r6_rom_needs_enable: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> ctl_q[EN_BIT]);

endmodule

// File: tb/reset_boot_selector_bench.sv
module reset_boot_selector_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_sen_n = 1'b1;
    logic        s_ea = 1'b0;
    logic        s_ale = 1'b0;
    logic [7:0]  nv_status = 8'h00;
    logic [7:0]  nv_vector = 8'hFC;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [15:0] fetch_addr = 16'h0000;
    logic [15:0] start_pc;
    logic [7:0]  ctl_q;
    logic        rom_sel;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit started = 1'b0;
    bit done = 1'b0;

    logic [15:0] m_pc;
    logic [7:0]  m_ctl;

    always #5 clk = ~clk;

    reset_boot_selector u_reset_boot_selector (
        .clk              (clk),
        .rst              (rst),
        .strap_store_en_n (s_sen_n),
        .strap_ext_access (s_ea),
        .strap_latch_en   (s_ale),
        .nv_status        (nv_status),
        .nv_vector        (nv_vector),
        .ctl_wr           (ctl_wr),
        .ctl_wdata        (ctl_wdata),
        .fetch_addr       (fetch_addr),
        .start_pc         (start_pc),
        .ctl_q            (ctl_q),
        .rom_sel          (rom_sel)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit entry;
        if (rst) begin
            entry = (nv_status != 0) || (s_sen_n == 0 && s_ea == 1 && s_ale == 1);
            m_pc  = entry ? {nv_vector, 8'h00} : 16'h0000;
            m_ctl = entry ? 8'h20 : 8'h00;
        end else if (ctl_wr) begin
            m_ctl = ctl_wdata;
        end
        started = 1'b1;
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            logic exp_rom;
            exp_rom = (fetch_addr >= 16'hFC00) && m_ctl[5];
            check(cur_req, "start_pc", int'(start_pc), int'(m_pc));
            check(cur_req, "ctl_q", int'(ctl_q), int'(m_ctl));
            check((fetch_addr >= 16'hFC00) ? "R6/R10" : "R7/R10", "rom_sel",
                  int'(rom_sel), int'(exp_rom));
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic boot(logic [7:0] st, logic [7:0] vec, logic sen_n, logic ea, logic ale);
        @(posedge clk); #1;
        rst = 1'b1;
        nv_status = st; nv_vector = vec;
        s_sen_n = sen_n; s_ea = ea; s_ale = ale;
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    task automatic sweep_fetch();
        logic [15:0] pts [8] = '{16'h0000, 16'h8000, 16'hFBFF, 16'hFC00,
                                 16'hFDFF, 16'hFFF0, 16'hFFFF, 16'h1234};
        for (int i = 0; i < 8; i++) begin
            fetch_addr = pts[i];
            #2;
            check("R10", "rom_sel same cycle", int'(rom_sel),
                  int'((pts[i] >= 16'hFC00) && ctl_q[5]));
            step(1);
        end
    endtask

    task automatic write_ctl(logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step(1);
        ctl_wr = 1'b0;
        check("R5", "ctl_q after write", int'(ctl_q), int'(v));
        step(1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: normal boot
        cur_req = "R1";
        boot(8'h00, 8'hFC, 1'b1, 1'b0, 1'b0);
        check("R1", "reset start_pc", int'(start_pc), 16'h0000);
        check("R4", "reset ctl_q normal", int'(ctl_q), 8'h00);
        sweep_fetch();

        // R2: nonzero status, default vector
        cur_req = "R2";
        boot(8'h5A, 8'hFC, 1'b1, 1'b0, 1'b0);
        check("R2", "start_pc from vector", int'(start_pc), 16'hFC00);
        check("R4", "boot enable set", int'(ctl_q), 8'h20);
        sweep_fetch();

        // R8: input changes after reset ignored
        cur_req = "R8";
        nv_status = 8'h00; nv_vector = 8'h33;
        s_sen_n = 1'b0; s_ea = 1'b1; s_ale = 1'b1;
        step(5);
        check("R8", "start_pc held", int'(start_pc), 16'hFC00);
        check("R8", "ctl_q held", int'(ctl_q), 8'h20);

        // R5: software rewrites
        cur_req = "R5";
        fetch_addr = 16'hFFF0;
        write_ctl(8'h00);
        check("R6", "rom off after clear", int'(rom_sel), 0);
        write_ctl(8'h20);
        check("R6", "rom on after set", int'(rom_sel), 1);
        write_ctl(8'hDF);
        check("R6", "rom off bit5 clear", int'(rom_sel), 0);
        write_ctl(8'hA5);
        sweep_fetch();

        // R3: straps force boot
        cur_req = "R3";
        boot(8'h00, 8'h12, 1'b0, 1'b1, 1'b1);
        check("R3", "strap start_pc", int'(start_pc), 16'h1200);
        check("R3", "strap ctl_q", int'(ctl_q), 8'h20);
        sweep_fetch();
        boot(8'h00, 8'h12, 1'b1, 1'b1, 1'b1);
        check("R3", "partial strap sen_n high", int'(start_pc), 16'h0000);
        boot(8'h00, 8'h12, 1'b0, 1'b0, 1'b1);
        check("R3", "partial strap ea low", int'(start_pc), 16'h0000);
        boot(8'h00, 8'h12, 1'b0, 1'b1, 1'b0);
        check("R3", "partial strap ale low", int'(start_pc), 16'h0000);
        check("R3", "partial strap ctl_q", int'(ctl_q), 8'h00);

        // R9: erased bytes
        cur_req = "R9";
        boot(8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0);
        check("R9", "erased start_pc", int'(start_pc), 16'hFF00);
        check("R9", "erased ctl_q", int'(ctl_q), 8'h20);
        sweep_fetch();

        // R11: write during reset ignored
        cur_req = "R11";
        @(posedge clk); #1;
        rst = 1'b1; nv_status = 8'h00;
        s_sen_n = 1'b1; s_ea = 1'b0; s_ale = 1'b0;
        ctl_wr = 1'b1; ctl_wdata = 8'hFF;
        step(3);
        ctl_wr = 1'b0;
        rst = 1'b0;
        step(1);
        check("R11", "write in reset ignored", int'(ctl_q), 8'h00);
        fetch_addr = 16'hFFFF;
        #2;
        check("R11", "rom_sel after ignored write", int'(rom_sel), 0);
        step(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule